// File: doc/BRIEF.md
# Half-Cycle Duty Cycle Clock Post-Divider

This block divides a fast source clock by an integer count C and shapes the divided output with a separately programmed high time. The high time is given in half-source-cycle units H, so one output period spans 2C half-cycles. The output stays high for H of them and low for the remaining 2C−H. The duty cycle can therefore be set in steps of 50%/C. Half-cycle resolution comes from a rising-edge counter and a falling-edge register. Their outputs are combined by one AND gate whose two inputs never change at the same edge.

A count of one bypasses the counter and passes the source clock through unchanged. A feedback-lock input forces the high time to exactly C half-cycles, which gives a 50% duty cycle whatever high time is requested. An illegal request raises an error flag and is not applied. An illegal request is a count of zero, a high time of zero, or a high time of 2C−1 or more, which is the step nearest 100%. New settings take effect only at the start of an output period.

Top module: `pdc_divider`

## Requirements
- R1: The output period is C source cycles. Each period starts at a rising source edge with the output high, and the output is high for exactly H half-cycles.
- R2: An odd H ends the high phase at a falling source edge, after (H−1)/2 full source cycles plus one half-cycle.
- R3: With C = 10, every H from 1 to 18 is legal, which covers duty cycles from 5% to 90% in 5% steps.
- R4: A request with C = 0, or with C ≥ 2, fb_lock50 = 0 and H outside 1..2C−2, sets cfg_err at the next rising edge. Such a request is never applied, and the divider keeps its previous setting. After reset the divider starts with C = 2, H = 2 if the first request is illegal.
- R5: With fb_lock50 = 1 and C ≥ 2, the high time is C half-cycles whatever high_half holds, and the request is legal.
- R6: With C = 1, clk_div equals the source clock, and high_half is ignored.
- R7: A change to div_cnt, high_half or fb_lock50 takes effect only at the first period start after the change. The output period in progress completes unchanged.
- R8: While rst is high at a rising edge, the output is held low and cfg_err reads 0. The first rising output edge is the first rising source edge after rst is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| div_cnt | input | CW | Division count C |
| high_half | input | CW+1 | Requested high time H in half-source-cycles |
| fb_lock50 | input | 1 | Forces a 50% duty cycle for an external feedback path |
| clk_div | output | 1 | Divided, duty-shaped output clock |
| cfg_err | output | 1 | Current request is illegal and is not applied |

## Verification
The output is sampled once in every half-source-cycle and compared with a waveform rebuilt from C and H. Even and odd H are both exercised, including H = 1 and the 90% limit at C = 10, which shows whether the falling-edge stage trims exactly one half-cycle. Requests with feedback lock, bypass, and illegal values such as H = 2C or C = 0 show whether forcing, pass-through and rejection act independently. Settings changed in the middle of a period, and changes into and out of bypass, show whether the new values wait for the period boundary.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // Legality of a divider request; arguments are zero-extended by the caller.
  function automatic logic pdc_cfg_ok(input logic [15:0] c, input logic [15:0] h,
                                      input logic fb);
    logic [16:0] hmax;
    hmax = {c, 1'b0} - 17'd2;
    if (c == 16'd0) return 1'b0;
    if (c == 16'd1) return 1'b1;
    if (fb) return 1'b1;
    return (h != 16'd0) && ({1'b0, h} <= hmax);
  endfunction

endpackage

// File: rtl/pdc_cfg_check.sv
module pdc_cfg_check #(
  parameter int CW = 8,
  localparam int HW = CW + 1
) (
  input  logic [CW-1:0] div_cnt,
  input  logic [HW-1:0] high_half,
  input  logic          fb_lock50,
  output logic          req_ok,
  output logic [HW-1:0] req_h
);
  import pdc_pkg::*;

  always_comb begin
    req_ok = pdc_cfg_ok(16'(div_cnt), 16'(high_half), fb_lock50);
    req_h  = fb_lock50 ? {1'b0, div_cnt} : high_half;
  end
endmodule

// File: rtl/pdc_rise_ctr.sv
module pdc_rise_ctr #(
  parameter int CW = 8,
  parameter int DEF_C = 2,
  parameter int DEF_H = 2,
  localparam int HW = CW + 1
) (
  input  logic          clk_src,
  input  logic          rst,
  input  logic [CW-1:0] div_cnt,
  input  logic          req_ok,
  input  logic [HW-1:0] req_h,
  output logic          run_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] act_c,
  output logic [HW-1:0] act_h,
  output logic          byp_q,
  output logic          a_q,
  output logic          cfg_err
);
  logic          at_start;
  logic [CW-1:0] cnt_nxt;
  logic [HW-1:0] hk;
  logic [CW-1:0] new_c;
  logic [HW-1:0] new_h;

  always_comb begin
    at_start = !run_q || (cnt_q == act_c - 1'b1);
    cnt_nxt  = cnt_q + 1'b1;
    // full source cycles in which the rising stage holds the output high
    hk       = (act_h >> 1) + {{(HW-1){1'b0}}, act_h[0]};
    new_c    = req_ok ? div_cnt : act_c;
    new_h    = req_ok ? req_h : act_h;
  end

  always_ff @(posedge clk_src) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      act_c   <= CW'(DEF_C);
      act_h   <= HW'(DEF_H);
      byp_q   <= 1'b0;
      a_q     <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= !req_ok;
      run_q   <= 1'b1;
      if (at_start) begin
        cnt_q <= '0;
        act_c <= new_c;
        act_h <= new_h;
        byp_q <= (new_c == CW'(1));
        a_q   <= (new_c != CW'(1));
      end else begin
        cnt_q <= cnt_nxt;
        a_q   <= ({1'b0, cnt_nxt} < hk);
      end
    end
  end
endmodule

// File: rtl/pdc_fall_stage.sv
module pdc_fall_stage #(
  parameter int CW = 8,
  localparam int HW = CW + 1
) (
  input  logic          clk_src,
  input  logic          rst,
  input  logic          run_q,
  input  logic          byp_q,
  input  logic [CW-1:0] cnt_q,
  input  logic [HW-1:0] act_h,
  output logic          f_q
);
  logic trim;

  // odd high time: cut the last rising-stage cycle in half
  always_comb trim = run_q && !byp_q && act_h[0] && ({1'b0, cnt_q} == (act_h >> 1));

  always_ff @(negedge clk_src) begin
    if (rst) f_q <= 1'b0;
    else     f_q <= trim;
  end
endmodule

// File: rtl/pdc_divider.sv
module pdc_divider #(
  parameter int CW = 8,
  localparam int HW = CW + 1
) (
  input  logic          clk_src,
  input  logic          rst,
  input  logic [CW-1:0] div_cnt,
  input  logic [HW-1:0] high_half,
  input  logic          fb_lock50,
  output logic          clk_div,
  output logic          cfg_err
);
  logic          req_ok;
  logic [HW-1:0] req_h;
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] act_c;
  logic [HW-1:0] act_h;
  logic          byp_q;
  logic          a_q;
  logic          f_q;

  pdc_cfg_check #(.CW(CW)) u_chk_cfg (
    .div_cnt(div_cnt), .high_half(high_half), .fb_lock50(fb_lock50),
    .req_ok(req_ok), .req_h(req_h)
  );

  pdc_rise_ctr #(.CW(CW)) u_rise (
    .clk_src(clk_src), .rst(rst), .div_cnt(div_cnt), .req_ok(req_ok), .req_h(req_h),
    .run_q(run_q), .cnt_q(cnt_q), .act_c(act_c), .act_h(act_h), .byp_q(byp_q),
    .a_q(a_q), .cfg_err(cfg_err)
  );

  pdc_fall_stage #(.CW(CW)) u_fall (
    .clk_src(clk_src), .rst(rst), .run_q(run_q), .byp_q(byp_q), .cnt_q(cnt_q),
    .act_h(act_h), .f_q(f_q)
  );

  // a_q moves only on rising edges, f_q only on falling edges
  always_comb begin
    if (rst)        clk_div = 1'b0;
    else if (byp_q) clk_div = clk_src & run_q;
    else            clk_div = a_q & ~f_q;
  end
endmodule

// File: rtl/pdc_divider_chk.sv
module pdc_divider_chk #(
  parameter int CW = 8,
  localparam int HW = CW + 1
) (
  input logic          clk_src,
  input logic          rst,
  input logic [CW-1:0] div_cnt,
  input logic [HW-1:0] high_half,
  input logic          fb_lock50,
  input logic          cfg_err,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] act_c,
  input logic [HW-1:0] act_h,
  input logic          byp_q,
  input logic          a_q,
  input logic          f_q
);
  import pdc_pkg::*;
  logic req_legal;
  always_comb req_legal = pdc_cfg_ok(16'(div_cnt), 16'(high_half), fb_lock50);

  a_r1_cnt_in_period: assert property (@(posedge clk_src) disable iff (rst)
    cnt_q < act_c);
  a_r2_trim_odd_only: assert property (@(posedge clk_src) disable iff (rst)
    f_q |-> act_h[0]);
  a_r4_err_set: assert property (@(posedge clk_src) disable iff (rst)
    !req_legal |=> cfg_err);
  a_r4_err_clear: assert property (@(posedge clk_src) disable iff (rst)
    req_legal |=> !cfg_err);
  a_r6_bypass_idle_cnt: assert property (@(posedge clk_src) disable iff (rst)
    byp_q |-> (cnt_q == '0));
  a_r7_hold_mid_period: assert property (@(posedge clk_src) disable iff (rst)
    (cnt_q != '0) |-> ($stable(act_c) && $stable(act_h)));
  a_r8_first_edge: assert property (@(posedge clk_src)
    $fell(rst) |=> (a_q || byp_q));
endmodule

bind pdc_divider pdc_divider_chk #(.CW(CW)) u_pdc_chk (
  .clk_src(clk_src), .rst(rst), .div_cnt(div_cnt), .high_half(high_half),
  .fb_lock50(fb_lock50), .cfg_err(cfg_err), .cnt_q(cnt_q), .act_c(act_c),
  .act_h(act_h), .byp_q(byp_q), .a_q(a_q), .f_q(f_q)
);

// File: tb/tb_pdc_divider.sv
module tb_pdc_divider;
  localparam int CW = 8;
  localparam int HW = CW + 1;
  localparam int NS = 60;     // half-cycle slots sampled per vector
  localparam int NV = 16;
  localparam int NOCHG = 999;

  // c0, h0, fb0, c1, h1, fb1, slot after which c1/h1/fb1 are driven
  localparam int TBL [NV][7] = '{
    '{10,  1, 0, 10,  1, 0, NOCHG},  // R3 R2: 5%
    '{10, 18, 0, 10, 18, 0, NOCHG},  // R3: 90%
    '{10,  9, 0, 10,  9, 0, NOCHG},  // R2 odd, 45%
    '{ 4,  3, 0,  4,  3, 0, NOCHG},  // R1 R2
    '{ 3,  2, 0,  3,  2, 0, NOCHG},  // R1 odd count
    '{ 2,  1, 0,  2,  1, 0, NOCHG},  // R2 single half-cycle
    '{ 7, 11, 0,  7, 11, 0, NOCHG},  // R1
    '{10,  3, 1, 10,  3, 1, NOCHG},  // R5 forced 50%
    '{ 5,  1, 1,  5,  1, 1, NOCHG},  // R5 odd count forced
    '{ 1,  0, 0,  1,  0, 0, NOCHG},  // R6 bypass
    '{ 0,  5, 0,  0,  5, 0, NOCHG},  // R4 C=0 -> default
    '{ 3,  6, 0,  3,  6, 0, NOCHG},  // R4 H=2C -> default
    '{ 4,  3, 0,  4,  5, 0, 11},     // R7 mid-period change
    '{ 4,  3, 0,  4,  7, 0, 11},     // R4 illegal change kept out
    '{ 3,  2, 0,  1,  0, 0, 9},      // R6 R7 into bypass
    '{ 1,  0, 0,  5,  4, 0, 7}       // R6 R7 out of bypass
  };

  logic          clk_src = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] div_cnt = '0;
  logic [HW-1:0] high_half = '0;
  logic          fb_lock50 = 1'b0;
  logic          clk_div;
  logic          cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  logic samp [NS];

  pdc_divider #(.CW(CW)) dut (
    .clk_src(clk_src), .rst(rst), .div_cnt(div_cnt), .high_half(high_half),
    .fb_lock50(fb_lock50), .clk_div(clk_div), .cfg_err(cfg_err)
  );

  always #10 clk_src = ~clk_src;

  function automatic bit legal(int c, int h, int fb);
    if (c == 0) return 0;
    if (c == 1) return 1;
    if (fb != 0) return 1;
    return (h >= 1) && (h <= 2 * c - 2);
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(int c, int h, int fb);
    div_cnt   = CW'(c);
    high_half = HW'(h);
    fb_lock50 = (fb != 0);
  endtask

  task automatic do_reset(int c, int h, int fb);
    @(posedge clk_src); #2;
    rst = 1'b1;
    drive(c, h, fb);
    repeat (3) @(posedge clk_src);
    #2 rst = 1'b0;
  endtask

  task automatic run_vec(int v);
    int cur_c, cur_h, pos, ic, ih, ifb, bad, bad_slot;
    bit expv;
    do_reset(TBL[v][0], TBL[v][1], TBL[v][2]);
    for (int i = 0; i < NS / 2; i++) begin
      @(posedge clk_src);
      #5 samp[2*i] = clk_div;
      if (2*i == TBL[v][6]) drive(TBL[v][3], TBL[v][4], TBL[v][5]);
      #10 samp[2*i+1] = clk_div;
      if (2*i+1 == TBL[v][6]) drive(TBL[v][3], TBL[v][4], TBL[v][5]);
    end
    // reference waveform from C and H, settings taken at period starts
    cur_c = 2; cur_h = 2; pos = 0; bad = 0; bad_slot = -1;
    for (int j = 0; j < NS; j++) begin
      if ((j % 2 == 0) && pos == 0) begin
        ic  = (j > TBL[v][6]) ? TBL[v][3] : TBL[v][0];
        ih  = (j > TBL[v][6]) ? TBL[v][4] : TBL[v][1];
        ifb = (j > TBL[v][6]) ? TBL[v][5] : TBL[v][2];
        if (legal(ic, ih, ifb)) begin
          cur_c = ic;
          cur_h = (ifb != 0) ? ic : ih;
        end
      end
      if (cur_c == 1) expv = (j % 2 == 0);
      else            expv = ((2 * pos + j % 2) < cur_h);
      if (samp[j] !== expv && bad_slot < 0) begin
        bad_slot = j;
        bad = int'(samp[j]);
      end
      if (j % 2 == 1) pos = (pos + 1) % cur_c;
    end
    check(bad_slot < 0, "R1/R7", bad, 1 - bad,
          $sformatf("waveform vector %0d first bad slot %0d", v, bad_slot));
    check(cfg_err === !legal(TBL[v][3], TBL[v][4], TBL[v][5]), "R4", int'(cfg_err),
          int'(!legal(TBL[v][3], TBL[v][4], TBL[v][5])),
          $sformatf("cfg_err vector %0d", v));
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8: reset holds output low and flag clear even for an illegal request
    drive(0, 0, 0);
    repeat (3) @(posedge clk_src);
    for (int k = 0; k < 2; k++) begin
      @(posedge clk_src);
      #5 check(clk_div === 1'b0, "R8", int'(clk_div), 0, "output high phase in reset");
      #10 check(clk_div === 1'b0, "R8", int'(clk_div), 0, "output low phase in reset");
      check(cfg_err === 1'b0, "R8", int'(cfg_err), 0, "cfg_err in reset");
    end
    for (int v = 0; v < NV; v++) run_vec(v);
    // R3: every step of the C=10 range is accepted
    do_reset(10, 1, 0);
    for (int h = 1; h <= 18; h++) begin
      drive(10, h, 0);
      @(posedge clk_src); #5;
      check(cfg_err === 1'b0, "R3", int'(cfg_err), 0, $sformatf("C=10 H=%0d flagged", h));
    end
    // R4: the step nearest 100% is rejected; R5: lock makes it legal
    drive(10, 19, 0);
    @(posedge clk_src); #5;
    check(cfg_err === 1'b1, "R4", int'(cfg_err), 1, "C=10 H=19 not flagged");
    drive(10, 19, 1);
    @(posedge clk_src); #5;
    check(cfg_err === 1'b0, "R5", int'(cfg_err), 0, "locked request flagged");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule